// File: doc/BRIEF.md
# Byte XOR instruction execution unit

This unit carries out a single two-operand logical operation, a bytewise exclusive-OR, for an 8-bit machine whose registers live in a 256-byte register file. A fetch stage gives it the two or three bytes of an already-fetched instruction together with a one-cycle start strobe. The unit latches those bytes and the upper nibble of the working-register base. It decodes one of five opcode forms and resolves the destination and source operands, following one level of indirection where the form asks for it. It writes `dst ^ src` back to the destination and updates the flag byte.

Every instruction runs for a fixed number of cycles that depends on its form. `done` is high during the final cycle, and the register-file write and the flag update take effect on the clock edge that closes that cycle. The register file and the flag byte can be loaded and read through a side port while the unit is idle. A test harness or a reset sequencer uses that port to set up and inspect state.

Top module: `xor_exec_unit`

## Requirements
- R1: When an instruction completes, the destination register holds the old destination value XOR the source operand. No other register changes.
- R2: The source operand is never written. This covers a source register, a pointer register, and the register reached through that pointer.
- R3: The flag byte uses this layout: bit 7 C, bit 6 Z, bit 5 S, bit 4 V, bit 3 D, bit 2 H, bits 1:0 spare. On completion Z is set exactly when the result is 00h, S copies result bit 7, and V is cleared.
- R4: On completion C, D, H and the two spare bits keep their previous values.
- R5: Opcode B2h takes 2 bytes and 4 cycles. Byte 1 holds the destination working register in bits 7:4 and the source working register in bits 3:0.
- R6: Opcode B3h takes 2 bytes and 6 cycles. It uses the same nibble packing as B2h, but the source working register holds the address of the operand.
- R7: Opcodes B4h and B5h take 3 bytes and 6 cycles. Byte 1 is the source address and byte 2 is the destination address. For B5h the register named by byte 1 holds the operand's address.
- R8: Opcode B6h takes 3 bytes and 6 cycles. Byte 1 is the destination address and byte 2 is the immediate source value.
- R9: Working register n (0..15) maps to register-file address {wp_base[7:4], n}, using the base value sampled with the start strobe.
- R10: Any other opcode raises `illegal` together with `done` in the first cycle after start. It changes neither the register file nor the flags.
- R11: `done` is high for exactly one cycle, the N-th cycle after the start edge, where N is the form's cycle count. A start strobe that arrives while busy is ignored.
- R12: After reset, `busy`, `done` and `illegal` are low and the flag byte is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (ignored while busy) |
| instr_b0 | input | 8 | Opcode byte |
| instr_b1 | input | 8 | First operand byte |
| instr_b2 | input | 8 | Second operand byte (3-byte forms) |
| wp_base | input | 8 | Working-register base; bits 7:4 are used |
| dbg_we | input | 1 | Side-port register write (idle only) |
| dbg_addr | input | 8 | Side-port write address |
| dbg_wdata | input | 8 | Side-port write data |
| dbg_flag_we | input | 1 | Side-port flag write (idle only) |
| dbg_flag_wdata | input | 8 | Side-port flag data |
| dbg_raddr | input | 8 | Side-port read address |
| dbg_rdata | output | 8 | Side-port read data (combinational) |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Final cycle of the instruction |
| illegal | output | 1 | Final cycle of an unsupported opcode |
| flags | output | 8 | Flag byte |

## Verification
A decode error that picks the wrong nibble, byte order or indirection level leaves a wrong value in some register, or writes the wrong register. The full register-file readback after each instruction shows this within a few cycles of `done`. A wrong cycle count or a stuck sequencer moves or repeats `done`, which the per-cycle strobe check catches in the same cycle. A flag-rule error shows on `flags` in the cycle right after completion. The bench presets C, D, H and the spare bits to several values so that a lost bit becomes visible.

// File: rtl/xor_exec_pkg.sv
package xor_exec_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = 4;

  // flag byte layout
  localparam int unsigned FLAG_C = 7;
  localparam int unsigned FLAG_Z = 6;
  localparam int unsigned FLAG_S = 5;
  localparam int unsigned FLAG_V = 4;
  localparam int unsigned FLAG_D = 3;
  localparam int unsigned FLAG_H = 2;

  localparam logic [BYTE_W-1:0] OPC_RR  = 8'hB2;
  localparam logic [BYTE_W-1:0] OPC_RIR = 8'hB3;
  localparam logic [BYTE_W-1:0] OPC_AA  = 8'hB4;
  localparam logic [BYTE_W-1:0] OPC_AIA = 8'hB5;
  localparam logic [BYTE_W-1:0] OPC_AIM = 8'hB6;

  function automatic logic [BYTE_W-1:0] xor_bytes(input logic [BYTE_W-1:0] a,
                                                 input logic [BYTE_W-1:0] b);
    return a ^ b;
  endfunction

  function automatic logic [BYTE_W-1:0] flag_next(input logic [BYTE_W-1:0] old_f,
                                                 input logic [BYTE_W-1:0] res);
    logic [BYTE_W-1:0] nf;
    nf         = old_f;
    nf[FLAG_Z] = (res == '0);
    nf[FLAG_S] = res[BYTE_W-1];
    nf[FLAG_V] = 1'b0;
    return nf;
  endfunction

  function automatic logic [BYTE_W-1:0] wreg_addr(input logic [NIB_W-1:0] base_hi,
                                                 input logic [NIB_W-1:0] n);
    return {base_hi, n};
  endfunction
endpackage

// File: rtl/xor_decode.sv
module xor_decode
  import xor_exec_pkg::*;
#(
  parameter int unsigned CYC_SHORT = 4,
  parameter int unsigned CYC_LONG  = 6,
  parameter int unsigned CNT_W     = $clog2(CYC_LONG + 1)
) (
  input  logic [BYTE_W-1:0] b0,
  input  logic [BYTE_W-1:0] b1,
  input  logic [BYTE_W-1:0] b2,
  input  logic [NIB_W-1:0]  base_hi,
  output logic              legal,
  output logic [BYTE_W-1:0] dst_addr,
  output logic [BYTE_W-1:0] dir_addr,
  output logic              src_ind,
  output logic              src_imm,
  output logic [BYTE_W-1:0] imm_val,
  output logic [CNT_W-1:0]  cycles
);
  logic [BYTE_W-1:0] w_dst, w_src;
  assign w_dst = wreg_addr(base_hi, b1[BYTE_W-1:NIB_W]);
  assign w_src = wreg_addr(base_hi, b1[NIB_W-1:0]);

  always_comb begin
    legal    = 1'b1;
    dst_addr = w_dst;
    dir_addr = w_src;
    src_ind  = 1'b0;
    src_imm  = 1'b0;
    imm_val  = b2;
    cycles   = CNT_W'(CYC_LONG);
    unique case (b0)
      OPC_RR:  cycles = CNT_W'(CYC_SHORT);
      OPC_RIR: src_ind = 1'b1;
      OPC_AA: begin
        dir_addr = b1;
        dst_addr = b2;
      end
      OPC_AIA: begin
        dir_addr = b1;
        dst_addr = b2;
        src_ind  = 1'b1;
      end
      OPC_AIM: begin
        dst_addr = b1;
        src_imm  = 1'b1;
      end
      default: begin
        legal  = 1'b0;
        cycles = CNT_W'(1);
      end
    endcase
  end
endmodule

// File: rtl/xor_regfile.sv
module xor_regfile #(
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 8,
  parameter int unsigned NRD = 4,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [DW-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/xor_seq.sv
module xor_seq #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cycles,
  output logic             busy,
  output logic             accept,
  output logic             final_cyc
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy      = busy_q;
  assign accept    = start & ~busy_q;
  assign final_cyc = busy_q & (cnt_q == cycles);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(1);
    end else if (final_cyc) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    final_cyc |=> !final_cyc);
  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !final_cyc) |=> busy_q);
endmodule

// File: rtl/xor_exec_unit.sv
module xor_exec_unit
  import xor_exec_pkg::*;
#(
  parameter int unsigned CYC_SHORT = 4,
  parameter int unsigned CYC_LONG  = 6,
  localparam int unsigned CNT_W    = $clog2(CYC_LONG + 1),
  localparam int unsigned NRD      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] instr_b0,
  input  logic [BYTE_W-1:0] instr_b1,
  input  logic [BYTE_W-1:0] instr_b2,
  input  logic [BYTE_W-1:0] wp_base,
  input  logic              dbg_we,
  input  logic [BYTE_W-1:0] dbg_addr,
  input  logic [BYTE_W-1:0] dbg_wdata,
  input  logic              dbg_flag_we,
  input  logic [BYTE_W-1:0] dbg_flag_wdata,
  input  logic [BYTE_W-1:0] dbg_raddr,
  output logic [BYTE_W-1:0] dbg_rdata,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic [BYTE_W-1:0] flags
);
  logic [BYTE_W-1:0] b0_q, b1_q, b2_q;
  logic [NIB_W-1:0]  base_q;
  logic [BYTE_W-1:0] flags_q;

  logic              accept, final_cyc, legal, src_ind, src_imm;
  logic [CNT_W-1:0]  cycles;
  logic [BYTE_W-1:0] dst_addr, dir_addr, imm_val, src_addr, src_val, result;
  logic              commit, rf_we;
  logic [BYTE_W-1:0] rf_waddr, rf_wdata;
  logic [NRD-1:0][BYTE_W-1:0] rd_addr, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b0_q   <= '0;
      b1_q   <= '0;
      b2_q   <= '0;
      base_q <= '0;
    end else if (accept) begin
      b0_q   <= instr_b0;
      b1_q   <= instr_b1;
      b2_q   <= instr_b2;
      base_q <= wp_base[BYTE_W-1:BYTE_W-NIB_W];
    end
  end

  xor_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cycles(cycles),
    .busy(busy), .accept(accept), .final_cyc(final_cyc)
  );

  xor_decode #(.CYC_SHORT(CYC_SHORT), .CYC_LONG(CYC_LONG), .CNT_W(CNT_W)) u_dec (
    .b0(b0_q), .b1(b1_q), .b2(b2_q), .base_hi(base_q),
    .legal(legal), .dst_addr(dst_addr), .dir_addr(dir_addr),
    .src_ind(src_ind), .src_imm(src_imm), .imm_val(imm_val), .cycles(cycles)
  );

  // read ports: 0 destination, 1 direct/pointer, 2 indirect target, 3 side port
  assign src_addr   = src_ind ? rd_data[1] : dir_addr;
  assign rd_addr[0] = dst_addr;
  assign rd_addr[1] = dir_addr;
  assign rd_addr[2] = src_addr;
  assign rd_addr[3] = dbg_raddr;
  assign dbg_rdata  = rd_data[3];

  assign src_val = src_imm ? imm_val : rd_data[2];
  assign result  = xor_bytes(rd_data[0], src_val);

  assign commit  = final_cyc & legal;
  assign done    = final_cyc;
  assign illegal = final_cyc & ~legal;

  assign rf_we    = commit | (dbg_we & ~busy);
  assign rf_waddr = commit ? dst_addr : dbg_addr;
  assign rf_wdata = commit ? result : dbg_wdata;

  xor_regfile #(.DW(BYTE_W), .AW(BYTE_W), .NRD(NRD)) u_rf (
    .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      flags_q <= '0;
    else if (commit)                 flags_q <= flag_next(flags_q, result);
    else if (dbg_flag_we && !busy)   flags_q <= dbg_flag_wdata;
  end
  assign flags = flags_q;

  // R1
  dst_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (rd_data[0] == $past(result)));
  // R3
  v_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !flags_q[FLAG_V]);
  // R4
  c_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (flags_q[FLAG_C] == $past(flags_q[FLAG_C])));
  // R10
  illegal_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable(flags_q));
  // R10
  illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !rf_we);
endmodule

// File: tb/xor_exec_unit_tb.sv
module xor_exec_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] b0 = '0, b1 = '0, b2 = '0, wp = '0;
  logic       dbg_we = 1'b0, dbg_flag_we = 1'b0;
  logic [7:0] dbg_addr = '0, dbg_wdata = '0, dbg_flag_wdata = '0, dbg_raddr = '0;
  logic [7:0] dbg_rdata, flags;
  logic       busy, done, illegal;

  int checks = 0;
  int errors = 0;
  logic [7:0] sh [256];
  logic [7:0] sh_flags;

  always #4 clk = ~clk;

  xor_exec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .instr_b0(b0), .instr_b1(b1), .instr_b2(b2), .wp_base(wp),
    .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
    .dbg_flag_we(dbg_flag_we), .dbg_flag_wdata(dbg_flag_wdata),
    .dbg_raddr(dbg_raddr), .dbg_rdata(dbg_rdata),
    .busy(busy), .done(done), .illegal(illegal), .flags(flags)
  );

  // {opcode, byte1, byte2, base, preset flags}
  localparam logic [39:0] VEC [10] = '{
    {8'hB2, 8'h31, 8'h00, 8'h40, 8'h00},
    {8'hB2, 8'hF0, 8'h99, 8'hA7, 8'hFF},
    {8'hB3, 8'h25, 8'h00, 8'h10, 8'h8C},
    {8'hB3, 8'h7E, 8'h11, 8'hF0, 8'h13},
    {8'hB4, 8'h05, 8'h90, 8'h00, 8'h0F},
    {8'hB4, 8'hC3, 8'hC3, 8'h00, 8'hF0},
    {8'hB5, 8'h12, 8'h34, 8'h00, 8'h80},
    {8'hB5, 8'hEE, 8'h0A, 8'h60, 8'h0C},
    {8'hB6, 8'h44, 8'hA5, 8'h00, 8'h04},
    {8'hB6, 8'h80, 8'h00, 8'h00, 8'h73}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_reg(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    dbg_we = 1'b1; dbg_addr = a; dbg_wdata = v;
    @(posedge clk); #1 dbg_we = 1'b0;
    sh[a] = v;
  endtask

  task automatic load_flags(input logic [7:0] v);
    @(negedge clk);
    dbg_flag_we = 1'b1; dbg_flag_wdata = v;
    @(posedge clk); #1 dbg_flag_we = 1'b0;
    sh_flags = v;
  endtask

  task automatic compare_rf(input string req);
    int bad = 0;
    int first_a = -1;
    for (int a = 0; a < 256; a++) begin
      dbg_raddr = 8'(a); #0.5;
      if (dbg_rdata !== sh[a]) begin
        bad++;
        if (first_a < 0) first_a = a;
      end
    end
    if (first_a >= 0) begin
      dbg_raddr = 8'(first_a); #0.5;
      chk(0, req, dbg_rdata, sh[first_a]);
    end else chk(1, req, 0, 0);
  endtask

  // Independent model: expected cycles, shadow update and flags
  task automatic model(input logic [7:0] o0, input logic [7:0] o1, input logic [7:0] o2,
                       input logic [7:0] base, output int n, output bit ok);
    logic [7:0] d, s, r;
    ok = 1'b1; n = 6;
    case (o0)
      8'hB2: begin n = 4; d = {base[7:4], o1[7:4]}; s = sh[{base[7:4], o1[3:0]}]; end
      8'hB3: begin d = {base[7:4], o1[7:4]}; s = sh[sh[{base[7:4], o1[3:0]}]]; end
      8'hB4: begin d = o2; s = sh[o1]; end
      8'hB5: begin d = o2; s = sh[sh[o1]]; end
      8'hB6: begin d = o1; s = o2; end
      default: begin n = 1; ok = 1'b0; d = '0; s = '0; end
    endcase
    if (ok) begin
      r = sh[d] ^ s;
      sh[d] = r;
      sh_flags = {sh_flags[7], r == 8'h00, r[7], 1'b0, sh_flags[3:0]};
    end
  endtask

  task automatic run(input logic [7:0] o0, input logic [7:0] o1, input logic [7:0] o2,
                     input logic [7:0] base, input bit interfere, input string tag);
    int n;
    bit ok;
    bit tim_ok = 1'b1;
    int bad_cyc = 0;
    model(o0, o1, o2, base, n, ok);
    @(negedge clk);
    start = 1'b1; b0 = o0; b1 = o1; b2 = o2; wp = base;
    @(posedge clk); #1 start = 1'b0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (done !== (i == n) || busy !== 1'b1 || illegal !== (!ok && i == n)) begin
        tim_ok = 1'b0; bad_cyc = i;
      end
      if (interfere && i == 2) begin
        start = 1'b1; b0 = 8'hB2; b1 = 8'h01; wp = 8'h00;
      end
      @(posedge clk); #1 start = 1'b0;
    end
    @(negedge clk);
    chk(tim_ok && !done && !busy, {"R11 R5 R6 R7 R8 R10 done timing ", tag}, bad_cyc, n);
    chk(flags === sh_flags, {"R3 R4 R10 flags ", tag}, flags, sh_flags);
    compare_rf({"R1 R2 R9 register file ", tag});
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    sh_flags = '0;
    #3;
    chk(busy === 1'b0 && done === 1'b0 && illegal === 1'b0, "R12 strobes in reset",
        {busy, done, illegal}, 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(flags === 8'h00, "R12 flags after reset", flags, 0);
    chk(busy === 1'b0 && done === 1'b0, "R12 idle after reset", {busy, done}, 0);

    for (int a = 0; a < 256; a++) load_reg(8'(a), 8'(a * 37 + 11));

    // table walk
    for (int v = 0; v < 10; v++) begin
      load_flags(VEC[v][7:0]);
      run(VEC[v][39:32], VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], 1'b0,
          $sformatf("vector %0d", v));
    end

    // R5 R9 worked example: base 20h, R0=C7h, R1=02h
    load_reg(8'h20, 8'hC7); load_reg(8'h21, 8'h02); load_reg(8'h00, 8'h2B);
    load_reg(8'h01, 8'h02); load_reg(8'h02, 8'h23);
    run(8'hB2, 8'h01, 8'h00, 8'h20, 1'b0, "R5 rr example");
    dbg_raddr = 8'h20; #0.5;
    chk(dbg_rdata === 8'hC5, "R5 R9 result C5h", dbg_rdata, 8'hC5);
    dbg_raddr = 8'h00; #0.5;
    chk(dbg_rdata === 8'h2B, "R9 absolute 00h untouched", dbg_rdata, 8'h2B);

    // R6 indirect working register: C5h ^ reg[02h]=23h -> E6h
    run(8'hB3, 8'h01, 8'h00, 8'h20, 1'b0, "R6 indirect");
    dbg_raddr = 8'h20; #0.5;
    chk(dbg_rdata === 8'hE6, "R6 result E6h", dbg_rdata, 8'hE6);

    // R7 indirect address: 2Bh ^ 23h -> 08h
    run(8'hB5, 8'h01, 8'h00, 8'h00, 1'b0, "R7 indirect");
    dbg_raddr = 8'h00; #0.5;
    chk(dbg_rdata === 8'h08, "R7 result 08h", dbg_rdata, 8'h08);
    dbg_raddr = 8'h02; #0.5;
    chk(dbg_rdata === 8'h23, "R2 pointed register kept", dbg_rdata, 8'h23);

    // R8 immediate: 2Bh ^ 54h -> 7Fh
    load_reg(8'h00, 8'h2B);
    run(8'hB6, 8'h00, 8'h54, 8'h00, 1'b0, "R8 immediate");
    dbg_raddr = 8'h00; #0.5;
    chk(dbg_rdata === 8'h7F, "R8 result 7Fh", dbg_rdata, 8'h7F);

    // R3 zero result sets Z, same source and destination
    load_flags(8'hFF);
    run(8'hB4, 8'h33, 8'h33, 8'h00, 1'b0, "R3 zero");
    chk(flags === 8'hCF, "R3 Z set S V clear", flags, 8'hCF);

    // R10 unsupported opcodes
    load_flags(8'h5A);
    run(8'hB7, 8'h00, 8'h11, 8'h00, 1'b0, "R10 opcode B7h");
    run(8'h00, 8'h12, 8'h00, 8'h00, 1'b0, "R10 opcode 00h");

    // R11 start while busy is ignored
    run(8'hB6, 8'h10, 8'h0F, 8'h00, 1'b1, "R11 start while busy");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule